// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Byte Engine

This block is the byte-level slave controller for a 512-byte serial EEPROM on a two-wire I2C bus. A front end outside the block finds the bus conditions. It hands the block single-cycle strobes for start, stop, SCL rising and SCL falling, together with the sampled SDA level. The block returns one registered signal that pulls SDA low through the open-drain pad. It decodes the device header and acknowledges every byte it accepts. It also owns the 9-bit word pointer.

Received write bytes go to an external page write sequencer as push strobes, each carrying its full address. A stop then commits the batch, and a fresh start throws the batch away. Read bytes come from a synchronous memory port that the pointer addresses. Data for a pointer value is expected one clock after that value appears. While the sequencer reports busy, the engine stays silent. A master can therefore poll with headers until an acknowledge returns.

Top module: `eep_slave_engine`

## Requirements
- R1: After reset the pointer (`mem_rd_addr`) is 0, `sda_drive_low` is 0 and none of `wr_push`, `wr_commit` or `wr_drop` pulses.
- R2: A header byte (MSB first) is accepted only when bits 7..4 are 1010, bit 3 equals `sel_a2` and bit 2 equals `sel_a1`. An accepted header is acknowledged by driving SDA low in the ninth clock. After a mismatch the block never drives SDA until the next start.
- R3: A write header (bit 0 = 0) is followed by a word address byte and data bytes, and each of these is acknowledged. The header's bit 1 becomes address bit 8 and the word byte gives bits 7..0. Each data byte produces one `wr_push` with its address and data. A stop after at least one pushed byte produces one `wr_commit`.
- R4: Within a multi-byte write, only pointer bits 3..0 advance: from xxxx1111 they wrap to xxxx0000 and bits 8..4 stay fixed.
- R5: A read header (bit 0 = 1) returns the byte at the current pointer, whatever its bit 1 holds. The pointer then rests one past the last byte read or written.
- R6: During a read, a master acknowledge (SDA low in the ninth clock) sends the next byte, and the pointer wraps from 0x1FF to 0x000.
- R7: If the master does not acknowledge a read byte, SDA stays released for all further clocks until a start or stop.
- R8: A write header and word address followed by a repeated start (dummy write) loads the pointer and produces neither `wr_commit` nor `wr_drop`.
- R9: A start that arrives after data bytes were pushed but before a stop produces one `wr_drop` and no `wr_commit`.
- R10: While `seq_busy` is high, starts, stops and headers are ignored and no acknowledge is driven. A header after `seq_busy` falls is acknowledged normally.
- R11: A stop in the middle of a read data byte releases SDA on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| start_det | input | 1 | Start condition strobe |
| stop_det | input | 1 | Stop condition strobe |
| scl_rise | input | 1 | SCL rising edge strobe |
| scl_fall | input | 1 | SCL falling edge strobe |
| sda_in | input | 1 | Sampled SDA level |
| sel_a2 | input | 1 | Upper slave select strap |
| sel_a1 | input | 1 | Lower slave select strap |
| seq_busy | input | 1 | Sequencer is programming the array |
| mem_rd_addr | output | 9 | Read port address (current pointer) |
| mem_rd_data | input | 8 | Read port data, one clock after the address |
| wr_push | output | 1 | One write byte is ready for the sequencer |
| wr_addr | output | 9 | Address of the pushed byte |
| wr_data | output | 8 | Pushed byte |
| wr_commit | output | 1 | Program the pushed bytes |
| wr_drop | output | 1 | Discard the pushed bytes |
| sda_drive_low | output | 1 | Pull SDA low |

## Verification
The assertions take the strobes to be single-cycle pulses and mutually exclusive, with at least two clocks between any two of them. They also take `seq_busy` to rise only while the bus is idle after a commit. The stimulus meets these conditions by construction. Every strobe is a one-clock pulse followed by at least two quiet clocks. SDA changes only between a falling strobe and the next rising strobe. `seq_busy` is raised and lowered only after a stop.

// File: rtl/eep_slv_pkg.sv
package eep_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADR,
    ST_WDAT,
    ST_RDAT,
    ST_HOLD
  } eng_state_t;
endpackage

// File: rtl/eep_rx_shift.sv
module eep_rx_shift #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [W-1:0]  byte_q,
  output logic          full
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      if (rst) byte_q <= '0;
    end else if (shift_en && cnt_q != CW'(W)) begin
      byte_q <= {byte_q[W-2:0], bit_in};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign full = (cnt_q == CW'(W));

  // R2
  bit_count_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(W));
endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
  parameter int AW = 9,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc_lin,
  input  logic          inc_page,
  output logic [AW-1:0] ptr_q
);
  always_ff @(posedge clk) begin
    if (rst)           ptr_q <= '0;
    else if (load)     ptr_q <= load_val;
    else if (inc_lin)  ptr_q <= ptr_q + 1'b1;
    else if (inc_page) ptr_q <= {ptr_q[AW-1:PW], ptr_q[PW-1:0] + 1'b1};
  end

  // R4
  page_upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    inc_page && !load |=> ptr_q[AW-1:PW] == $past(ptr_q[AW-1:PW]));
  // R6
  lin_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    inc_lin && !load && ptr_q == '1 |=> ptr_q == '0);
endmodule

// File: rtl/eep_slave_engine.sv
module eep_slave_engine
  import eep_slv_pkg::*;
#(
  parameter int         AW       = 9,
  parameter int         DW       = 8,
  parameter int         PW       = 4,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_in,
  input  logic          sel_a2,
  input  logic          sel_a1,
  input  logic          seq_busy,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          wr_push,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_commit,
  output logic          wr_drop,
  output logic          sda_drive_low
);
  eng_state_t    st_q;
  logic          ack_ph_q, mack_ok_q, page_q, rnw_q, pushed_q;
  logic [DW-1:0] tx_q, rx_byte;
  logic          rx_full;
  logic          ld, inc_l, inc_p;
  logic [AW-1:0] ptr;
  logic          hdr_match;

  eep_rx_shift #(.W(DW)) u_rx (
    .clk(clk), .rst(rst),
    .clr(start_det || (scl_fall && ack_ph_q)),
    .shift_en(scl_rise), .bit_in(sda_in),
    .byte_q(rx_byte), .full(rx_full)
  );

  eep_addr_ctr #(.AW(AW), .PW(PW)) u_ptr (
    .clk(clk), .rst(rst), .load(ld), .load_val({page_q, rx_byte}),
    .inc_lin(inc_l), .inc_page(inc_p), .ptr_q(ptr)
  );

  assign mem_rd_addr = ptr;
  assign hdr_match = (rx_byte[7:4] == DEV_CODE) && (rx_byte[3] == sel_a2)
                     && (rx_byte[2] == sel_a1);

  wire byte_end = scl_fall && !ack_ph_q && rx_full && !start_det && !stop_det;

  always_comb begin
    ld    = byte_end && st_q == ST_WADR;
    inc_p = byte_end && st_q == ST_WDAT;
    inc_l = byte_end && st_q == ST_RDAT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; ack_ph_q <= 1'b0; mack_ok_q <= 1'b0;
      page_q <= 1'b0; rnw_q <= 1'b0; pushed_q <= 1'b0;
      tx_q <= '0; sda_drive_low <= 1'b0;
      wr_push <= 1'b0; wr_commit <= 1'b0; wr_drop <= 1'b0;
      wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_push <= 1'b0; wr_commit <= 1'b0; wr_drop <= 1'b0;
      if (start_det) begin
        if (!seq_busy) begin
          st_q <= ST_DEV;
          wr_drop <= pushed_q;
          pushed_q <= 1'b0;
        end else begin
          st_q <= ST_IDLE;
        end
        ack_ph_q <= 1'b0; sda_drive_low <= 1'b0;
      end else if (stop_det) begin
        if (!seq_busy) begin
          wr_commit <= pushed_q;
          pushed_q <= 1'b0;
          st_q <= ST_IDLE; ack_ph_q <= 1'b0; sda_drive_low <= 1'b0;
        end
      end else if (scl_rise && ack_ph_q && st_q == ST_RDAT) begin
        mack_ok_q <= ~sda_in;
      end else if (scl_fall && !ack_ph_q) begin
        if (rx_full) begin
          unique case (st_q)
            ST_DEV: begin
              if (hdr_match) begin
                ack_ph_q <= 1'b1; sda_drive_low <= 1'b1;
                page_q <= rx_byte[1]; rnw_q <= rx_byte[0];
              end else begin
                st_q <= ST_HOLD;
              end
            end
            ST_WADR: begin ack_ph_q <= 1'b1; sda_drive_low <= 1'b1; end
            ST_WDAT: begin
              ack_ph_q <= 1'b1; sda_drive_low <= 1'b1;
              wr_push <= 1'b1; wr_addr <= ptr; wr_data <= rx_byte;
              pushed_q <= 1'b1;
            end
            ST_RDAT: begin ack_ph_q <= 1'b1; sda_drive_low <= 1'b0; end
            default: ;
          endcase
        end else if (st_q == ST_RDAT) begin
          tx_q <= {tx_q[DW-2:0], 1'b0};
          sda_drive_low <= ~tx_q[DW-2];
        end
      end else if (scl_fall && ack_ph_q) begin
        ack_ph_q <= 1'b0;
        sda_drive_low <= 1'b0;
        unique case (st_q)
          ST_DEV: begin
            if (rnw_q) begin
              st_q <= ST_RDAT; tx_q <= mem_rd_data;
              sda_drive_low <= ~mem_rd_data[DW-1];
            end else begin
              st_q <= ST_WADR;
            end
          end
          ST_WADR: st_q <= ST_WDAT;
          ST_RDAT: begin
            if (mack_ok_q) begin
              tx_q <= mem_rd_data;
              sda_drive_low <= ~mem_rd_data[DW-1];
            end else begin
              st_q <= ST_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  busy_silent_chk: assert property (@(posedge clk) disable iff (rst)
    start_det && seq_busy |=> !sda_drive_low);
  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det && !seq_busy |=> !sda_drive_low);
  // R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    st_q == ST_HOLD && !start_det |=> !sda_drive_low);
  // R9
  commit_drop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_commit && wr_drop));
  // R3
  push_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_push |=> !wr_push);
endmodule

// File: tb/eep_slave_engine_tb_top.sv
module eep_slave_engine_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic start_det = 0, stop_det = 0, scl_rise = 0, scl_fall = 0, sda_in = 1;
  logic sel_a2 = 1'b1, sel_a1 = 1'b0, seq_busy = 1'b0;
  logic [8:0] mem_rd_addr, wr_addr;
  logic [7:0] mem_rd_data, wr_data;
  logic wr_push, wr_commit, wr_drop, sda_drive_low;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  eep_slave_engine dut_i (.*);

  function automatic logic [7:0] mval(input logic [8:0] a);
    return (a[7:0] ^ 8'h5A) + {7'd0, a[8]};
  endfunction

  always_ff @(posedge clk) mem_rd_data <= mval(mem_rd_addr);

  // scoreboard item: kind 0 push, 1 commit, 2 drop
  typedef struct { int kind; logic [8:0] a; logic [7:0] d; } item_t;
  item_t expq[$];

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && (wr_push || wr_commit || wr_drop)) begin
      int k;
      k = wr_push ? 0 : (wr_commit ? 1 : 2);
      if (expq.size() == 0) begin
        check("R8 unexpected write event", k, 99);
      end else begin
        item_t e;
        e = expq.pop_front();
        check("R3/R9 event kind", k, e.kind);
        if (k == 0) begin
          check("R3/R4 push address", wr_addr, e.a);
          check("R3 push data", wr_data, e.d);
        end
      end
    end
  end

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: start_det = 1; 1: stop_det = 1; 2: scl_rise = 1; default: scl_fall = 1;
    endcase
    @(negedge clk);
    start_det = 0; stop_det = 0; scl_rise = 0; scl_fall = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic obs);
    sda_in = b;
    strobe(2);
    obs = sda_drive_low;
    strobe(3);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic o;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], o);
    clk_bit(1'b1, acked);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic o;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, o); v[i] = ~o; end
    clk_bit(~mack, o);
  endtask

  function automatic logic [7:0] hdr(input logic p, input logic rd);
    return {4'b1010, 1'b1, 1'b0, p, rd};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 pointer", mem_rd_addr, 0);
    check("R1 sda", sda_drive_low, 0);
    check("R1 pulses", wr_push | wr_commit | wr_drop, 0);

    // R5 current read from 0, P0 set but ignored; R2 header accepted
    strobe(0); send_byte(hdr(1, 1), ack);
    check("R2 header ack", ack, 1);
    recv_byte(0, v); check("R5 read data at 0", v, mval(9'h000));
    strobe(1);
    check("R5 pointer after read", mem_rd_addr, 9'h001);

    // R2 mismatched pins: no ack, quiet afterwards
    strobe(0); send_byte({4'b1010, 1'b0, 1'b1, 2'b00}, ack);
    check("R2 mismatch no ack", ack, 0);
    send_byte(8'h00, ack); check("R2 ignored after mismatch", ack, 0);
    strobe(1);

    // R3 byte write with P0 = 1
    expq.push_back('{0, 9'h135, 8'hA5});
    expq.push_back('{1, 0, 0});
    strobe(0); send_byte(hdr(1, 0), ack); check("R3 header ack", ack, 1);
    send_byte(8'h35, ack); check("R3 word ack", ack, 1);
    send_byte(8'hA5, ack); check("R3 data ack", ack, 1);
    strobe(1);
    check("R5 pointer after write", mem_rd_addr, 9'h136);

    // R5 current read after write
    strobe(0); send_byte(hdr(0, 1), ack);
    recv_byte(0, v); check("R5 read after write", v, mval(9'h136));
    strobe(1);

    // R4 page write wrapping within 16 bytes
    expq.push_back('{0, 9'h04E, 8'h11});
    expq.push_back('{0, 9'h04F, 8'h22});
    expq.push_back('{0, 9'h040, 8'h33});
    expq.push_back('{1, 0, 0});
    strobe(0); send_byte(hdr(0, 0), ack); send_byte(8'h4E, ack);
    send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack);
    check("R4 last byte ack", ack, 1);
    strobe(1);
    check("R4 pointer after page wrap", mem_rd_addr, 9'h041);

    // R8 dummy write then R6 sequential read across 0x1FF
    strobe(0); send_byte(hdr(1, 0), ack); send_byte(8'hFE, ack);
    check("R8 word ack", ack, 1);
    strobe(0); send_byte(hdr(0, 1), ack); check("R8 read header ack", ack, 1);
    recv_byte(1, v); check("R6 byte 0x1FE", v, mval(9'h1FE));
    recv_byte(1, v); check("R6 byte 0x1FF", v, mval(9'h1FF));
    recv_byte(0, v); check("R6 wrap to 0", v, mval(9'h000));
    // R7 no master ack: released for a full further byte
    recv_byte(0, v); check("R7 bus released", v, 8'hFF);
    strobe(1);
    check("R6 pointer after wrap", mem_rd_addr, 9'h001);

    // R9 start abandons a partial write
    expq.push_back('{0, 9'h010, 8'h77});
    expq.push_back('{2, 0, 0});
    strobe(0); send_byte(hdr(0, 0), ack); send_byte(8'h10, ack);
    send_byte(8'h77, ack);
    strobe(0);
    strobe(1);
    check("R9 queue drained", expq.size(), 0);

    // R10 busy suppresses responses
    seq_busy = 1;
    strobe(0); send_byte(hdr(0, 1), ack); check("R10 no ack while busy", ack, 0);
    strobe(1);
    seq_busy = 0;
    strobe(0); send_byte(hdr(0, 1), ack); check("R10 ack after busy", ack, 1);
    recv_byte(0, v);
    strobe(1);

    // R11 stop in mid read byte
    strobe(0); send_byte(hdr(0, 0), ack); send_byte(8'h20, ack);
    strobe(0); send_byte(hdr(0, 1), ack);
    check("R11 driving first bit low", sda_drive_low, 1);
    strobe(1);
    check("R11 released after stop", sda_drive_low, 0);

    repeat (4) @(negedge clk);
    check("R3 scoreboard empty", expq.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule